// File: doc/BRIEF.md
# Shifting Vector Accumulator with Reduce and Scan

The block holds a vector in an accumulator register A and a second register B. A vector is written into A right-justified, so element 0 occupies the lowest bits. A read port presents A shifted left by a 5-bit offset p. Bits shifted past the top of the 32-bit word are dropped and zeros enter at the bottom. A controller can use this port to pull out a left-aligned subvector of up to 32 bits. Register B copies A on command and drives its own 32-bit output.

The same datapath runs reduction and scan. Each step adds the lowest element of A, which is an `EW`-bit field, into B, and then shifts A right by one element. A scan marks each running total with a one-cycle valid pulse. A reduce gives only the final total, marked by a done pulse. B is not cleared when an operation starts, so its current contents act as the seed. A command to start while an operation is in progress has no effect.

Top module: `shiftvec_acc`

## Requirements
- R1: After reset, A and B are zero, and `busy`, `step_valid` and `done` are low.
- R2: When idle and `start` is low, `load_a` writes `a_in` into A unchanged, with `a_in[0]` at bit 0. The next cycle shows it on `dec_out` at offset 0.
- R3: `dec_out` equals A shifted left by `offset` (0 to 31). Bits that would land at index 32 or above are discarded, and the low `offset` bits are zero.
- R4: When idle and `start` is low, `copy_b` writes A into B, and `b_out` shows it on the next cycle. If `load_a` is asserted in the same cycle, B receives the value A had before the load.
- R5: A start while idle begins an operation of N = `cnt_m1`+1 steps (1 to 32). The start edge is step 1, and each following edge is one more step. Each step adds the zero-extended low `EW` bits of A into B, then shifts A right by `EW` bits with zeros filling from the top, so elements past the end of the vector add zero.
- R6: `done` is high for exactly the one cycle after step N. During that cycle `b_out` holds the final sum and `busy` is low.
- R7: `busy` is high from the cycle after step 1 through the cycle after step N-1. It never rises when N = 1.
- R8: In scan mode (`op_scan` = 1 at start), `step_valid` is high in the cycle after each of the N steps, and `b_out` then shows that running sum. In reduce mode (`op_scan` = 0), `step_valid` stays low.
- R9: Sums in B wrap modulo 2^32.
- R10: While `busy` is high, `start`, `op_scan`, `cnt_m1`, `load_a` and `copy_b` are ignored. The operation keeps its length, mode and result.
- R11: When idle, with no start and no copy, B holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_a | input | 1 | Write `a_in` into A |
| a_in | input | 32 | Right-justified vector to load |
| copy_b | input | 1 | Copy A into B |
| offset | input | 5 | Left shift applied on the read port |
| start | input | 1 | Begin a reduce or scan |
| op_scan | input | 1 | 1 selects scan, 0 selects reduce |
| cnt_m1 | input | 5 | Element count minus one |
| dec_out | output | 32 | A shifted left by `offset`, masked to 32 bits |
| b_out | output | 32 | Contents of B |
| busy | output | 1 | Operation in progress |
| step_valid | output | 1 | Running scan sum valid on `b_out` |
| done | output | 1 | Final sum valid on `b_out` |

## Verification
`dec_out` follows A combinationally, so a load or a shift shows up in the cycle after the edge that writes A, and a new offset shows up in the same cycle. Step j of an operation lands on the j-th edge, counting the start edge as the first. Its `step_valid` and `b_out` can therefore be read in the cycle after that edge, and `done` in the cycle after edge N. The bench drives inputs 2 ns after a rising edge and reads outputs 2 ns after the edges that follow. It counts edges from the start edge one at a time, so each expected value is checked in the exact cycle it is due, and the check also confirms it did not come one cycle early.

// File: rtl/shiftvec_acc.sv
module shiftvec_acc #(
  parameter int W     = 32,
  parameter int EW    = 8,
  parameter int MAXN  = 32,
  parameter int OFS_W = $clog2(W),
  parameter int CNT_W = $clog2(MAXN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_a,
  input  logic [W-1:0]     a_in,
  input  logic             copy_b,
  input  logic [OFS_W-1:0] offset,
  input  logic             start,
  input  logic             op_scan,
  input  logic [CNT_W-1:0] cnt_m1,
  output logic [W-1:0]     dec_out,
  output logic [W-1:0]     b_out,
  output logic             busy,
  output logic             step_valid,
  output logic             done
);
  logic [W-1:0]     a_q, b_q;
  logic [CNT_W-1:0] rem_q;
  logic             busy_q, scan_q, step_q, done_q;

  wire          fire = start && !busy_q;
  wire          adv  = fire || busy_q;
  wire [W-1:0]  elem = W'(a_q[EW-1:0]);
  wire [W-1:0]  sum  = b_q + elem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      scan_q <= 1'b0;
      step_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= 1'b0;
      done_q <= 1'b0;
      if (adv) begin
        a_q    <= a_q >> EW;
        b_q    <= sum;
        step_q <= fire ? op_scan : scan_q;
        if (fire) begin
          scan_q <= op_scan;
          rem_q  <= cnt_m1;
          busy_q <= (cnt_m1 != '0);
          done_q <= (cnt_m1 == '0);
        end else begin
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        if (load_a) a_q <= a_in;
        if (copy_b) b_q <= a_q;
      end
    end
  end

  assign dec_out    = a_q << offset;
  assign b_out      = b_q;
  assign busy       = busy_q;
  assign step_valid = step_q;
  assign done       = done_q;
endmodule

module shiftvec_acc_chk #(
  parameter int W     = 32,
  parameter int OFS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_a,
  input logic [W-1:0]     a_in,
  input logic             copy_b,
  input logic [OFS_W-1:0] offset,
  input logic             start,
  input logic [W-1:0]     dec_out,
  input logic [W-1:0]     b_out,
  input logic             busy,
  input logic             done
);
  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a && !busy && !start) |=> (offset != '0 || dec_out == $past(a_in))); // R2
  AST_COPY_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_b && !busy && !start && offset == '0) |=> (b_out == $past(dec_out))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !copy_b) |=> $stable(b_out)); // R11
endmodule

bind shiftvec_acc shiftvec_acc_chk #(.W(W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_a(load_a), .a_in(a_in), .copy_b(copy_b),
  .offset(offset), .start(start), .dec_out(dec_out), .b_out(b_out),
  .busy(busy), .done(done)
);

// File: tb/shiftvec_acc_bench.sv
`timescale 1ns/1ps
module shiftvec_acc_bench;
  logic        clk = 0, rst_n = 0;
  logic        load_a = 0, copy_b = 0, start = 0, op_scan = 0;
  logic [31:0] a_in = '0;
  logic [4:0]  offset = '0, cnt_m1 = '0;
  logic [31:0] dec_out, b_out;
  logic        busy, step_valid, done;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  shiftvec_acc u_shiftvec_acc (
    .clk(clk), .rst_n(rst_n), .load_a(load_a), .a_in(a_in), .copy_b(copy_b),
    .offset(offset), .start(start), .op_scan(op_scan), .cnt_m1(cnt_m1),
    .dec_out(dec_out), .b_out(b_out), .busy(busy), .step_valid(step_valid), .done(done)
  );

  task automatic tick; @(posedge clk); #2; endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_a(logic [31:0] v);
    load_a = 1; a_in = v; tick; load_a = 0;
  endtask

  task automatic set_b(logic [31:0] v);
    set_a(v); copy_b = 1; tick; copy_b = 0;
  endtask

  task automatic t_reset;
    offset = 0;
    chk("R1 dec_out", dec_out, 0);
    chk("R1 b_out", b_out, 0);
    chk("R1 flags", {29'd0, busy, step_valid, done}, 0);
  endtask

  task automatic t_decoder;
    set_a(32'h8000_0001);
    offset = 0;  #1 chk("R2 load offset0", dec_out, 32'h8000_0001);
    offset = 1;  #1 chk("R3 offset1", dec_out, 32'h0000_0002);
    offset = 31; #1 chk("R3 offset31 mask", dec_out, 32'h8000_0000);
    offset = 16; #1 chk("R3 offset16", dec_out, 32'h0001_0000);
    set_a(32'h5);
    offset = 29; #1 chk("R3 right-justified subvector", dec_out, 32'hA000_0000);
    offset = 0;
  endtask

  task automatic t_copy;
    set_a(32'h1234);
    copy_b = 1; load_a = 1; a_in = 32'h5678; tick; copy_b = 0; load_a = 0;
    chk("R4 copy takes old A", b_out, 32'h1234);
    chk("R2 same-cycle load", dec_out, 32'h5678);
    tick; tick;
    chk("R11 B holds", b_out, 32'h1234);
  endtask

  task automatic t_reduce4;
    set_b(0); set_a(32'h0403_0201);
    start = 1; op_scan = 0; cnt_m1 = 3; tick; start = 0;
    for (int j = 1; j < 4; j++) begin
      chk("R7 busy mid", {31'd0, busy}, 1);
      chk("R6 no early done", {31'd0, done}, 0);
      chk("R8 reduce no step_valid", {31'd0, step_valid}, 0);
      tick;
    end
    chk("R6 done", {31'd0, done}, 1);
    chk("R5 reduce sum", b_out, 10);
    chk("R6 busy low at done", {31'd0, busy}, 0);
    chk("R5 A drained", dec_out, 0);
    tick;
    chk("R6 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic t_reduce_past_end;
    set_b(0); set_a(32'h0101_0101);
    start = 1; op_scan = 0; cnt_m1 = 5; tick; start = 0;
    repeat (5) tick;
    chk("R5 elements past end add zero", b_out, 4);
    chk("R6 done N=6", {31'd0, done}, 1);
  endtask

  task automatic t_scan;
    logic [31:0] exp [4] = '{40, 70, 90, 100};
    set_b(0); set_a(32'h0A14_1E28);
    start = 1; op_scan = 1; cnt_m1 = 3; tick; start = 0; op_scan = 0;
    for (int j = 0; j < 4; j++) begin
      chk("R8 step_valid", {31'd0, step_valid}, 1);
      chk("R8 running sum", b_out, exp[j]);
      chk("R6 done only last", {31'd0, done}, (j == 3) ? 1 : 0);
      tick;
    end
    chk("R8 step_valid drops", {31'd0, step_valid}, 0);
  endtask

  task automatic t_wrap;
    set_b(32'hFFFF_FFFF); set_a(32'h03);
    start = 1; op_scan = 0; cnt_m1 = 0; tick; start = 0;
    chk("R9 wrap", b_out, 2);
    chk("R6 N=1 done", {31'd0, done}, 1);
    chk("R7 N=1 no busy", {31'd0, busy}, 0);
  endtask

  task automatic t_ignore;
    set_b(0); set_a(32'h0101_0101);
    start = 1; op_scan = 0; cnt_m1 = 3; tick; start = 0;
    start = 1; op_scan = 1; cnt_m1 = 0; load_a = 1; a_in = 32'hFFFF_FFFF; copy_b = 1;
    tick;
    chk("R10 no scan pulse", {31'd0, step_valid}, 0);
    chk("R10 no early done", {31'd0, done}, 0);
    start = 0; load_a = 0; copy_b = 0; op_scan = 0;
    tick; tick;
    chk("R10 done on time", {31'd0, done}, 1);
    chk("R10 sum kept", b_out, 4);
    chk("R10 A not loaded", dec_out, 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    t_reset;
    t_decoder;
    t_copy;
    t_reduce4;
    t_reduce_past_end;
    t_scan;
    t_wrap;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule